// File: doc/BRIEF.md
# Platform System Control Register Bank

A byte-wide register file placed on a simple synchronous I/O slave bus. It decodes a fixed set of 16-bit port addresses that hold platform control state (a held CPU soft-reset level, a little-endian mode flag, a disk-activity lamp bit, a four-bit system control field and an I/O address-map mode bit) together with several fixed identification bytes. Writes update control state or fire one-cycle lock pulses toward an external non-volatile memory. Reads return either live state or a constant code.

Each access is a single-cycle strobe (`rd_en` or `wr_en`). Control state changes at the clock edge that samples the write strobe. The block records the access in a small phase register: IDLE (no access), READ (decoded read), WRITE (decoded write) and FAULT (any access to an undecoded port). The transitions are as follows. Any state goes to WRITE on a decoded write. It goes to READ on a decoded read with no write. It goes to FAULT on an undecoded access. It goes to IDLE when no strobe is present. The output process drives the lock pulses and the error flag from the phase of the previous edge. Read data is registered on the read edge and held until the next read.

Top module: `sysctl_bank`

## Requirements
- R1: After reset, soft_rst_o, le_mode_o, lamp_o, map_mode_o, lock_a_o, lock_b_o, err_o and rdata are all 0, and reads of 0x0092, 0x081C and 0x0850 return 0x00.
- R2: A write to 0x0092 sets soft_rst_o to data bit 0 and le_mode_o to data bit 1. Both hold until the next write to 0x0092. A read of 0x0092 returns le_mode in bit 1 and zeros in every other bit.
- R3: Ports 0x0800, 0x0802 and 0x0803 read 0xEF, 0xAD and 0xE0. A write to them changes nothing and raises no error.
- R4: Port 0x080C reads 0x3C, 0x0818 reads 0x00, 0x0823 reads 0x03 and 0x0810 reads 0x39.
- R5: A write to 0x0808 sets lamp_o to data bit 0.
- R6: A write to 0x0810 drives lock_a_o high for exactly the one cycle after the write edge. A write to 0x0812 does the same on lock_b_o. The two pulses never coincide.
- R7: A write to 0x081C stores data bits 3:0. A read of that port returns them in bits 3:0, with bits 7:4 zero.
- R8: A write to 0x0850 sets map_mode_o to data bit 0. A read of that port returns that bit in bit 0, with zeros above.
- R9: A write to 0x0814 has no effect. Reads of 0x0814 and of the write-only ports 0x0808 and 0x0812 return 0xFF with no error.
- R10: A read of an undecoded port returns 0xFF. Any access to an undecoded port raises err_o for the one cycle after the access edge and leaves all register state unchanged.
- R11: rdata takes the new value in the cycle after the read edge and holds it until the next read. When rd_en and wr_en are both high, only the write is performed and rdata is kept.
- R12: Writes to the fixed-code ports 0x080C, 0x0818 and 0x0823 raise no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 16 | Port address |
| wdata | input | 8 | Write data |
| rd_en | input | 1 | Read strobe, one cycle per access |
| wr_en | input | 1 | Write strobe, one cycle per access |
| rdata | output | 8 | Registered read data |
| soft_rst_o | output | 1 | Held CPU soft-reset level |
| le_mode_o | output | 1 | Little-endian mode flag |
| lamp_o | output | 1 | Disk-activity lamp state |
| map_mode_o | output | 1 | I/O address-map mode bit |
| lock_a_o | output | 1 | Lock pulse, channel 1 |
| lock_b_o | output | 1 | Lock pulse, channel 2 |
| err_o | output | 1 | Undecoded-access error pulse |

## Verification
A corrupted control register surfaces on its dedicated output pin in the very next cycle. It also surfaces in the read-back byte one cycle after the next read of its port, so each write is followed by a read or a pin sample. A stuck or wrong phase state shows as a lock or error pulse that is missing, lasts more than one cycle, or lands on the wrong channel. The bench therefore samples these pulses both in the cycle after the access and in the cycle after that. A decode slip returns the wrong constant, or a spurious 0xFF together with err_o, on the first read of the affected port.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

    localparam int DATA_W = 8;

    // Port addresses; each value fixes which register a bus access reaches.
    localparam logic [15:0] PA_SYS92  = 16'h0092;
    localparam logic [15:0] PA_IDCPU  = 16'h0800;
    localparam logic [15:0] PA_IDFEAT = 16'h0802;
    localparam logic [15:0] PA_IDSTAT = 16'h0803;
    localparam logic [15:0] PA_LAMP   = 16'h0808;
    localparam logic [15:0] PA_EQUIP  = 16'h080C;
    localparam logic [15:0] PA_LOCKA  = 16'h0810;
    localparam logic [15:0] PA_LOCKB  = 16'h0812;
    localparam logic [15:0] PA_CINV   = 16'h0814;
    localparam logic [15:0] PA_KEY    = 16'h0818;
    localparam logic [15:0] PA_SCTL   = 16'h081C;
    localparam logic [15:0] PA_CACHE  = 16'h0823;
    localparam logic [15:0] PA_MAP    = 16'h0850;

    // Fixed read codes
    localparam logic [DATA_W-1:0] CODE_IDCPU  = 8'hEF;
    localparam logic [DATA_W-1:0] CODE_IDFEAT = 8'hAD;
    localparam logic [DATA_W-1:0] CODE_IDSTAT = 8'hE0;
    localparam logic [DATA_W-1:0] CODE_EQUIP  = 8'h3C;
    localparam logic [DATA_W-1:0] CODE_XFEAT  = 8'h39;
    localparam logic [DATA_W-1:0] CODE_KEY    = 8'h00;
    localparam logic [DATA_W-1:0] CODE_CACHE  = 8'h03;
    localparam logic [DATA_W-1:0] CODE_OPEN   = 8'hFF;

    typedef enum logic [3:0] {
        P_NONE, P_SYS92, P_IDCPU, P_IDFEAT, P_IDSTAT, P_LAMP, P_EQUIP,
        P_LOCKA, P_LOCKB, P_CINV, P_KEY, P_SCTL, P_CACHE, P_MAP
    } port_e;

    typedef enum logic [1:0] {
        PH_IDLE, PH_READ, PH_WRITE, PH_FAULT
    } phase_e;

endpackage

// File: rtl/sysctl_decode.sv
module sysctl_decode
    import sysctl_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic [ADDR_W-1:0] addr,
    output port_e             port
);
    always_comb begin
        unique case (addr)
            ADDR_W'(PA_SYS92):  port = P_SYS92;
            ADDR_W'(PA_IDCPU):  port = P_IDCPU;
            ADDR_W'(PA_IDFEAT): port = P_IDFEAT;
            ADDR_W'(PA_IDSTAT): port = P_IDSTAT;
            ADDR_W'(PA_LAMP):   port = P_LAMP;
            ADDR_W'(PA_EQUIP):  port = P_EQUIP;
            ADDR_W'(PA_LOCKA):  port = P_LOCKA;
            ADDR_W'(PA_LOCKB):  port = P_LOCKB;
            ADDR_W'(PA_CINV):   port = P_CINV;
            ADDR_W'(PA_KEY):    port = P_KEY;
            ADDR_W'(PA_SCTL):   port = P_SCTL;
            ADDR_W'(PA_CACHE):  port = P_CACHE;
            ADDR_W'(PA_MAP):    port = P_MAP;
            default:            port = P_NONE;
        endcase
    end
endmodule

// File: rtl/sysctl_regs.sv
module sysctl_regs
    import sysctl_pkg::*;
#(
    parameter int SCTL_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  port_e             port,
    input  logic [DATA_W-1:0] wdata,
    output logic              soft_rst,
    output logic              le_mode,
    output logic              lamp,
    output logic [SCTL_W-1:0] sctl,
    output logic              map_mode
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            soft_rst <= 1'b0;
            le_mode  <= 1'b0;
            lamp     <= 1'b0;
            sctl     <= '0;
            map_mode <= 1'b0;
        end else if (we) begin
            unique case (port)
                P_SYS92: begin
                    soft_rst <= wdata[0];
                    le_mode  <= wdata[1];
                end
                P_LAMP:  lamp     <= wdata[0];
                P_SCTL:  sctl     <= wdata[SCTL_W-1:0];
                P_MAP:   map_mode <= wdata[0];
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/sysctl_bank.sv
module sysctl_bank
    import sysctl_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int SCTL_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    input  logic              rd_en,
    input  logic              wr_en,
    output logic [7:0]        rdata,
    output logic              soft_rst_o,
    output logic              le_mode_o,
    output logic              lamp_o,
    output logic              map_mode_o,
    output logic              lock_a_o,
    output logic              lock_b_o,
    output logic              err_o
);
    localparam int PAD_W = DATA_W - SCTL_W;

    port_e             port_d;
    port_e             port_q;
    phase_e            phase_q;
    phase_e            phase_d;
    logic [SCTL_W-1:0] sctl;
    logic [DATA_W-1:0] rd_mux;
    logic [DATA_W-1:0] rdata_q;
    logic              hit;

    sysctl_decode #(.ADDR_W(ADDR_W)) u_decode (
        .addr (addr),
        .port (port_d)
    );

    assign hit = (port_d != P_NONE);

    sysctl_regs #(.SCTL_W(SCTL_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (wr_en && hit),
        .port     (port_d),
        .wdata    (wdata),
        .soft_rst (soft_rst_o),
        .le_mode  (le_mode_o),
        .lamp     (lamp_o),
        .sctl     (sctl),
        .map_mode (map_mode_o)
    );

    // Next phase
    always_comb begin
        if (wr_en)      phase_d = hit ? PH_WRITE : PH_FAULT;
        else if (rd_en) phase_d = hit ? PH_READ  : PH_FAULT;
        else            phase_d = PH_IDLE;
    end

    // Phase register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            port_q  <= P_NONE;
        end else begin
            phase_q <= phase_d;
            port_q  <= port_d;
        end
    end

    // Read multiplexer
    always_comb begin
        unique case (port_d)
            P_SYS92:  rd_mux = {6'b0, le_mode_o, 1'b0};
            P_IDCPU:  rd_mux = CODE_IDCPU;
            P_IDFEAT: rd_mux = CODE_IDFEAT;
            P_IDSTAT: rd_mux = CODE_IDSTAT;
            P_EQUIP:  rd_mux = CODE_EQUIP;
            P_LOCKA:  rd_mux = CODE_XFEAT;
            P_KEY:    rd_mux = CODE_KEY;
            P_SCTL:   rd_mux = {{PAD_W{1'b0}}, sctl};
            P_CACHE:  rd_mux = CODE_CACHE;
            P_MAP:    rd_mux = {7'b0, map_mode_o};
            default:  rd_mux = CODE_OPEN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                rdata_q <= '0;
        else if (rd_en && !wr_en)  rdata_q <= rd_mux;
    end

    assign rdata = rdata_q;

    // Outputs from phase
    always_comb begin
        lock_a_o = 1'b0;
        lock_b_o = 1'b0;
        err_o    = 1'b0;
        unique case (phase_q)
            PH_WRITE: begin
                lock_a_o = (port_q == P_LOCKA);
                lock_b_o = (port_q == P_LOCKB);
            end
            PH_FAULT: err_o = 1'b1;
            default:  ;
        endcase
    end
endmodule

// File: rtl/sysctl_bank_chk.sv
module sysctl_bank_chk #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] addr,
    input logic              rd_en,
    input logic              wr_en,
    input logic [7:0]        rdata,
    input logic              soft_rst_o,
    input logic              map_mode_o,
    input logic              lock_a_o,
    input logic              lock_b_o,
    input logic              err_o
);
    // R6
    lock_a_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lock_a_o |-> $past(wr_en && addr == ADDR_W'(16'h0810)));
    // R6
    lock_b_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lock_b_o |-> $past(wr_en && addr == ADDR_W'(16'h0812)));
    // R6
    pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({lock_a_o, lock_b_o, err_o}));
    // R10
    err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> $past(rd_en || wr_en));
    // R2
    srst_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(wr_en && addr == ADDR_W'(16'h0092)) |-> $stable(soft_rst_o));
    // R8
    map_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(wr_en && addr == ADDR_W'(16'h0850)) |-> $stable(map_mode_o));
    // R11
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rd_en) |-> $stable(rdata));
endmodule

bind sysctl_bank sysctl_bank_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .addr       (addr),
    .rd_en      (rd_en),
    .wr_en      (wr_en),
    .rdata      (rdata),
    .soft_rst_o (soft_rst_o),
    .map_mode_o (map_mode_o),
    .lock_a_o   (lock_a_o),
    .lock_b_o   (lock_b_o),
    .err_o      (err_o)
);

// File: tb/test_sysctl_bank.sv
module test_sysctl_bank;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] addr = '0;
    logic [7:0]  wdata = '0;
    logic        rd_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  rdata;
    logic        soft_rst_o, le_mode_o, lamp_o, map_mode_o;
    logic        lock_a_o, lock_b_o, err_o;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    sysctl_bank i_sysctl_bank (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata),
        .rd_en(rd_en), .wr_en(wr_en), .rdata(rdata),
        .soft_rst_o(soft_rst_o), .le_mode_o(le_mode_o), .lamp_o(lamp_o),
        .map_mode_o(map_mode_o), .lock_a_o(lock_a_o), .lock_b_o(lock_b_o),
        .err_o(err_o)
    );

    // Vector: {write, requirement number, address, data, expected read}
    localparam int NV = 24;
    localparam logic [36:0] VEC [NV] = '{
        {1'b0, 4'd1, 16'h0092, 8'h00, 8'h00},  // R1
        {1'b0, 4'd1, 16'h081C, 8'h00, 8'h00},  // R1
        {1'b0, 4'd1, 16'h0850, 8'h00, 8'h00},  // R1
        {1'b0, 4'd3, 16'h0800, 8'h00, 8'hEF},  // R3
        {1'b0, 4'd3, 16'h0802, 8'h00, 8'hAD},  // R3
        {1'b0, 4'd3, 16'h0803, 8'h00, 8'hE0},  // R3
        {1'b0, 4'd4, 16'h080C, 8'h00, 8'h3C},  // R4
        {1'b0, 4'd4, 16'h0818, 8'h00, 8'h00},  // R4
        {1'b0, 4'd4, 16'h0823, 8'h00, 8'h03},  // R4
        {1'b0, 4'd4, 16'h0810, 8'h00, 8'h39},  // R4
        {1'b0, 4'd9, 16'h0814, 8'h00, 8'hFF},  // R9
        {1'b0, 4'd9, 16'h0808, 8'h00, 8'hFF},  // R9
        {1'b0, 4'd9, 16'h0812, 8'h00, 8'hFF},  // R9
        {1'b1, 4'd3, 16'h0800, 8'h12, 8'h00},  // R3 write ignored
        {1'b0, 4'd3, 16'h0800, 8'h00, 8'hEF},  // R3
        {1'b1, 4'd7, 16'h081C, 8'hA5, 8'h00},  // R7
        {1'b0, 4'd7, 16'h081C, 8'h00, 8'h05},  // R7
        {1'b1, 4'd8, 16'h0850, 8'hFE, 8'h00},  // R8 bit0 clear
        {1'b0, 4'd8, 16'h0850, 8'h00, 8'h00},  // R8
        {1'b1, 4'd8, 16'h0850, 8'hFF, 8'h00},  // R8
        {1'b0, 4'd8, 16'h0850, 8'h00, 8'h01},  // R8
        {1'b1, 4'd2, 16'h0092, 8'hFE, 8'h00},  // R2 only bit1 counts
        {1'b0, 4'd2, 16'h0092, 8'h00, 8'h02},  // R2
        {1'b0, 4'd10, 16'h1234, 8'h00, 8'hFF}  // R10
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    // One access; returns at the negedge after the sampling edge.
    task automatic access(input bit wr, input bit rd, input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = wr; rd_en = rd;
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
    endtask

    task automatic idle();
        @(negedge clk);
    endtask

    logic [7:0] held;

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 outputs", {1'b0, soft_rst_o, le_mode_o, lamp_o, map_mode_o, lock_a_o, lock_b_o, err_o}, 8'h00);
        check("R1 rdata", rdata, 8'h00);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            access(VEC[i][36], !VEC[i][36], VEC[i][31:16], VEC[i][15:8]);
            if (!VEC[i][36])
                check($sformatf("R%0d read %04h", VEC[i][35:32], VEC[i][31:16]), rdata, VEC[i][7:0]);
        end

        // R2 soft reset level held, endian flag
        access(1, 0, 16'h0092, 8'h01);
        check("R2 soft_rst set", {6'b0, soft_rst_o, le_mode_o}, 8'h02);
        access(1, 0, 16'h0808, 8'h01);
        idle();
        check("R2 soft_rst held", {7'b0, soft_rst_o}, 8'h01);
        // R5 lamp
        check("R5 lamp on", {7'b0, lamp_o}, 8'h01);
        access(1, 0, 16'h0808, 8'hFE);
        check("R5 lamp off", {7'b0, lamp_o}, 8'h00);
        access(1, 0, 16'h0092, 8'h02);
        check("R2 le only", {6'b0, soft_rst_o, le_mode_o}, 8'h01);

        // R6 lock pulses
        access(1, 0, 16'h0810, 8'h00);
        check("R6 lock_a pulse", {6'b0, lock_a_o, lock_b_o}, 8'h02);
        idle();
        check("R6 lock_a end", {6'b0, lock_a_o, lock_b_o}, 8'h00);
        access(1, 0, 16'h0812, 8'h00);
        check("R6 lock_b pulse", {6'b0, lock_a_o, lock_b_o}, 8'h01);
        idle();
        check("R6 lock_b end", {6'b0, lock_a_o, lock_b_o}, 8'h00);

        // R8 map mode pin (set to 1 by the table)
        check("R8 map pin", {7'b0, map_mode_o}, 8'h01);

        // R9 write to 0x0814 changes nothing
        access(1, 0, 16'h0814, 8'h00);
        check("R9 no err", {7'b0, err_o}, 8'h00);
        check("R9 state", {5'b0, le_mode_o, lamp_o, map_mode_o}, 8'h05);

        // R10 undecoded read and write
        access(0, 1, 16'hFFFF, 8'h00);
        check("R10 read err", {7'b0, err_o}, 8'h01);
        check("R10 read data", rdata, 8'hFF);
        idle();
        check("R10 err one cycle", {7'b0, err_o}, 8'h00);
        access(1, 0, 16'h091C, 8'h0A);
        check("R10 write err", {7'b0, err_o}, 8'h01);
        access(0, 1, 16'h081C, 8'h00);
        check("R10 sctl unchanged", rdata, 8'h05);
        check("R10 pins unchanged", {4'b0, soft_rst_o, le_mode_o, lamp_o, map_mode_o}, 8'h05);

        // R12 writes to fixed-code ports
        access(1, 0, 16'h080C, 8'h00);
        check("R12 080C no err", {7'b0, err_o}, 8'h00);
        access(1, 0, 16'h0818, 8'h00);
        check("R12 0818 no err", {7'b0, err_o}, 8'h00);
        access(1, 0, 16'h0823, 8'h00);
        check("R12 0823 no err", {7'b0, err_o}, 8'h00);
        access(0, 1, 16'h0823, 8'h00);
        check("R12 0823 code", rdata, 8'h03);

        // R11 hold and simultaneous strobes
        held = rdata;
        repeat (4) idle();
        check("R11 rdata hold", rdata, held);
        access(1, 1, 16'h081C, 8'h0C);
        check("R11 both strobes keep rdata", rdata, held);
        access(0, 1, 16'h081C, 8'h00);
        check("R11 both strobes wrote", rdata, 8'h0C);

        // R7 nibble boundary
        access(1, 0, 16'h081C, 8'hF0);
        access(0, 1, 16'h081C, 8'h00);
        check("R7 upper bits dropped", rdata, 8'h00);

        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule